// File: doc/BRIEF.md
# ATA Task-File Address Remapper

This block sits between a removable-card host bus and the register port of an ATA task file. Every host access carries an address, a two-bit addressing-mode select, read and write strobes and a 16-bit write word. The address is folded onto a 16-entry register index according to the mode. There are four modes: a memory window, a contiguous 16-byte I/O window, and the legacy primary and secondary I/O windows, each of which has a command block and a control block. Accesses to task-file registers go out on the task-file port in the same cycle as a single-cycle strobe. Read data returns combinationally.

A few indices are served locally. These are the device-control / alternate-status pair, the synthesised device-address readback, and an odd-byte lane that lets an 8-bit host build one 16-bit data word from two byte accesses. A control write with the soft-reset bit set raises a one-cycle reset request. Ordinary register writes wake the card from power-down and flag it ready.

Top module: `ata_tf_remap`

## Requirements
- R1: After synchronous reset, `ctrl_byte`, `pd_state`, `rdy_flag` and `srst_req` are 0, the byte-lane toggle is in its first phase, and with no strobe active `tf_rd`, `tf_wr` and `host_rdata` are 0.
- R2: With `mode`=0 (memory window), offsets 0x000-0x00F map to index = offset, and every offset from 0x400 to 0x7FF maps to index 0.
- R3: With `mode`=1 (contiguous I/O), the index is the low four address bits, for any address.
- R4: With `mode`=2 (primary I/O), 0x1F0-0x1FF map to address minus 0x1F0, and 0x3F0-0x3F7 map to address minus 0x3E8 (so 0x3F6 is index 0xE).
- R5: With `mode`=3 (secondary I/O), 0x170-0x17F map to address minus 0x170, and 0x370-0x377 map to address minus 0x368.
- R6: An address that matches no window of the selected mode produces no task-file strobe, reads as 0, and changes no state.
- R7: Index 0 and index 8 reach task-file register 0. Index 0xD reaches task-file register 1. Indices 1-7 and 0xA-0xC keep their own number. In each case a read raises `tf_rd` and returns `tf_rdata`, and a write raises `tf_wr` with `tf_wdata` = `host_wdata`, all in the same cycle. A cycle with both strobes is treated as a write.
- R8: A read of index 0xE returns `{8'h00, tf_status}` when `drv_present` is 1 and 0 otherwise, with no task-file strobe.
- R9: A read of index 0xF returns `{8'h00, 8'hC2 | {2'b00, ~sel_nib, 2'b00}}` with no task-file strobe. A write to index 0xF is forwarded as task-file register 0xF.
- R10: A write to index 0xE is not forwarded. Its low byte appears on `ctrl_byte` after the clock edge. When bit 2 of that byte is 1, `srst_req` is 1 for the following cycle, and power-down, ready and the byte-lane toggle are cleared.
- R11: `pd_set` sets `pd_state` and clears `rdy_flag`. A forwarded write to index 1-7, 0xA-0xC or 0xF while `pd_state` is 1 clears `pd_state` and sets `rdy_flag`. Writes to index 0, 8, 9 or 0xD do not wake the card. A soft reset (R10) overrides `pd_set`, and `pd_set` overrides a wake.
- R12: A read of index 9 in the first phase reads task-file register 0, returns the low byte and keeps the high byte. A read of index 9 in the second phase returns the kept byte without a strobe. Each such read flips the phase.
- R13: A write of index 9 in the first phase keeps `host_wdata[7:0]`. A write of index 9 in the second phase writes task-file register 0 with `{host_wdata[7:0], kept byte}`. Each such write flips the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Addressing-mode select (0 memory, 1 contiguous, 2 primary, 3 secondary) |
| host_addr | input | HADDR_W (11) | Host byte address within the card window |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | DATA_W (16) | Host write data |
| host_rdata | output | DATA_W (16) | Read data, valid in the strobe cycle |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| tf_idx | output | 4 | Task-file register number |
| tf_wdata | output | DATA_W (16) | Task-file write data |
| tf_rdata | input | DATA_W (16) | Task-file read data |
| tf_status | input | 8 | Current device status byte |
| drv_present | input | 1 | A drive is attached |
| sel_nib | input | 4 | Low nibble of the drive/head select register |
| pd_set | input | 1 | Enter power-down |
| ctrl_byte | output | 8 | Stored device-control byte |
| srst_req | output | 1 | One-cycle soft-reset request |
| pd_state | output | 1 | Card is in power-down |
| rdy_flag | output | 1 | Card woke from power-down by a register write |

## Verification
A byte-lane toggle left in the wrong phase shows on the very next index-9 access: a read returns the stale kept byte instead of fresh task-file data, or a write gets forwarded one byte early. A stuck power-down or ready bit shows on the ports one cycle after the waking write. A wrong window decode shows in the strobe cycle itself, as a wrong `tf_idx`, a missing strobe, or a strobe on an address that should be ignored. The random stimulus biases addresses toward the window bases, so that all four maps and every local index are visited many times, with the phase of the toggle carried across accesses.

// File: rtl/ata_remap_pkg.sv
package ata_remap_pkg;

    typedef enum logic [1:0] {
        AM_MEM    = 2'd0,
        AM_CONTIG = 2'd1,
        AM_PRI    = 2'd2,
        AM_SEC    = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        K_DATA,
        K_ODD,
        K_ERRFEAT,
        K_CTRL,
        K_DEVADDR,
        K_PASS
    } ikind_e;

    typedef struct packed {
        logic       hit;
        logic [3:0] idx;
    } dec_t;

    localparam logic [3:0] TF_DATA_REG    = 4'h0;
    localparam logic [3:0] TF_ERRFEAT_REG = 4'h1;
    localparam logic [7:0] DEVADDR_FIXED  = 8'hC2;
    localparam int         SRST_BIT       = 2;

    function automatic ikind_e classify(input logic [3:0] idx);
        ikind_e k;
        case (idx)
            4'h0, 4'h8: k = K_DATA;
            4'h9:       k = K_ODD;
            4'hD:       k = K_ERRFEAT;
            4'hE:       k = K_CTRL;
            4'hF:       k = K_DEVADDR;
            default:    k = K_PASS;
        endcase
        return k;
    endfunction

    function automatic logic [7:0] devaddr_value(input logic [3:0] sel);
        return DEVADDR_FIXED | {2'b00, ~sel, 2'b00};
    endfunction

endpackage

// File: rtl/tf_addr_decode.sv
module tf_addr_decode
    import ata_remap_pkg::*;
#(
    parameter int AW = 11
) (
    input  amode_e        mode,
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    localparam int HI_W = AW - 4;
    localparam logic [HI_W-1:0] PRI_CMD = HI_W'(12'h1F0 >> 4);
    localparam logic [HI_W-1:0] PRI_CTL = HI_W'(12'h3F0 >> 4);
    localparam logic [HI_W-1:0] SEC_CMD = HI_W'(12'h170 >> 4);
    localparam logic [HI_W-1:0] SEC_CTL = HI_W'(12'h370 >> 4);

    logic [HI_W-1:0] hi;
    assign hi = addr[AW-1:4];

    always_comb begin
        dec.hit = 1'b0;
        dec.idx = addr[3:0];
        case (mode)
            AM_MEM: begin
                if (hi == '0) begin
                    dec.hit = 1'b1;
                end else if (addr[AW-1:10] == (AW-10)'(1)) begin
                    dec.hit = 1'b1;
                    dec.idx = TF_DATA_REG;
                end
            end
            AM_CONTIG: dec.hit = 1'b1;
            AM_PRI, AM_SEC: begin
                if (hi == ((mode == AM_PRI) ? PRI_CMD : SEC_CMD)) begin
                    dec.hit = 1'b1;
                end else if (hi == ((mode == AM_PRI) ? PRI_CTL : SEC_CTL) && !addr[3]) begin
                    dec.hit = 1'b1;
                    dec.idx = {1'b1, addr[2:0]};
                end
            end
            default: dec.hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tf_byte_lane.sv
module tf_byte_lane #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          rd_evt,
    input  logic          wr_evt,
    input  logic [BW-1:0] rd_hi,
    input  logic [BW-1:0] wr_lo,
    output logic          cyc,
    output logic [BW-1:0] hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc  <= 1'b0;
            hold <= '0;
        end else if (clr) begin
            cyc <= 1'b0;
        end else if (rd_evt || wr_evt) begin
            cyc <= ~cyc;
            if (!cyc) hold <= rd_evt ? rd_hi : wr_lo;
        end
    end

    p_phase_flip_r12: assert property (@(posedge clk) disable iff (rst)
        (rd_evt || wr_evt) && !clr |=> cyc != $past(cyc));

    p_clr_first_phase_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> !cyc);
endmodule

// File: rtl/tf_local_regs.sv
module tf_local_regs
    import ata_remap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_in,
    input  logic       pd_set,
    input  logic       wake,
    output logic [7:0] ctrl,
    output logic       srst_req,
    output logic       pd,
    output logic       rdy
);
    logic soft_rst;
    assign soft_rst = ctrl_we && ctrl_in[SRST_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            srst_req <= 1'b0;
            pd       <= 1'b0;
            rdy      <= 1'b0;
        end else begin
            srst_req <= soft_rst;
            if (ctrl_we) ctrl <= ctrl_in;
            if (soft_rst) begin
                pd  <= 1'b0;
                rdy <= 1'b0;
            end else if (pd_set) begin
                pd  <= 1'b1;
                rdy <= 1'b0;
            end else if (wake && pd) begin
                pd  <= 1'b0;
                rdy <= 1'b1;
            end
        end
    end

    p_ready_after_wake_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $past(wake && pd));

    p_pd_fall_cause_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(pd) |-> $past(wake || soft_rst));

    p_srst_with_ctrl_r10: assert property (@(posedge clk) disable iff (rst)
        srst_req |-> ctrl[SRST_BIT]);
endmodule

// File: rtl/ata_tf_remap.sv
module ata_tf_remap
    import ata_remap_pkg::*;
#(
    parameter int HADDR_W = 11,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         mode,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               tf_rd,
    output logic               tf_wr,
    output logic [3:0]         tf_idx,
    output logic [DATA_W-1:0]  tf_wdata,
    input  logic [DATA_W-1:0]  tf_rdata,
    input  logic [7:0]         tf_status,
    input  logic               drv_present,
    input  logic [3:0]         sel_nib,
    input  logic               pd_set,
    output logic [7:0]         ctrl_byte,
    output logic               srst_req,
    output logic               pd_state,
    output logic               rdy_flag
);
    localparam int BYTE_W = DATA_W / 2;

    dec_t        dec;
    ikind_e      kind;
    logic        acc_rd, acc_wr;
    logic        odd_rd, odd_wr, ctrl_we, wake, lane_cyc;
    logic [BYTE_W-1:0] lane_hold;

    tf_addr_decode #(.AW(HADDR_W)) u_dec (
        .mode (amode_e'(mode)),
        .addr (host_addr),
        .dec  (dec)
    );

    assign kind   = classify(dec.idx);
    assign acc_wr = host_wr && dec.hit;
    assign acc_rd = host_rd && !host_wr && dec.hit;

    always_comb begin
        tf_rd      = 1'b0;
        tf_wr      = 1'b0;
        tf_idx     = TF_DATA_REG;
        tf_wdata   = host_wdata;
        host_rdata = '0;
        odd_rd     = 1'b0;
        odd_wr     = 1'b0;
        ctrl_we    = 1'b0;
        wake       = 1'b0;
        case (kind)
            K_DATA: begin
                tf_rd = acc_rd;
                tf_wr = acc_wr;
                if (acc_rd) host_rdata = tf_rdata;
            end
            K_ODD: begin
                odd_rd = acc_rd;
                odd_wr = acc_wr;
                if (!lane_cyc) begin
                    tf_rd = acc_rd;
                    if (acc_rd) host_rdata = DATA_W'(tf_rdata[BYTE_W-1:0]);
                end else begin
                    tf_wr    = acc_wr;
                    tf_wdata = {host_wdata[BYTE_W-1:0], lane_hold};
                    if (acc_rd) host_rdata = DATA_W'(lane_hold);
                end
            end
            K_ERRFEAT: begin
                tf_idx = TF_ERRFEAT_REG;
                tf_rd  = acc_rd;
                tf_wr  = acc_wr;
                if (acc_rd) host_rdata = tf_rdata;
            end
            K_CTRL: begin
                ctrl_we = acc_wr;
                if (acc_rd && drv_present) host_rdata = DATA_W'(tf_status);
            end
            K_DEVADDR: begin
                tf_idx = dec.idx;
                tf_wr  = acc_wr;
                wake   = acc_wr;
                if (acc_rd) host_rdata = DATA_W'(devaddr_value(sel_nib));
            end
            default: begin
                tf_idx = dec.idx;
                tf_rd  = acc_rd;
                tf_wr  = acc_wr;
                wake   = acc_wr;
                if (acc_rd) host_rdata = tf_rdata;
            end
        endcase
    end

    tf_byte_lane #(.BW(BYTE_W)) u_lane (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctrl_we && host_wdata[SRST_BIT]),
        .rd_evt (odd_rd),
        .wr_evt (odd_wr),
        .rd_hi  (tf_rdata[DATA_W-1:BYTE_W]),
        .wr_lo  (host_wdata[BYTE_W-1:0]),
        .cyc    (lane_cyc),
        .hold   (lane_hold)
    );

    tf_local_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (ctrl_we),
        .ctrl_in  (host_wdata[7:0]),
        .pd_set   (pd_set),
        .wake     (wake),
        .ctrl     (ctrl_byte),
        .srst_req (srst_req),
        .pd       (pd_state),
        .rdy      (rdy_flag)
    );

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(tf_rd && tf_wr));

    p_ctrl_local_r10: assert property (@(posedge clk) disable iff (rst)
        (tf_rd || tf_wr) |-> tf_idx != 4'hE);

    p_miss_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (host_rd || host_wr) && !dec.hit |-> !tf_rd && !tf_wr && host_rdata == '0);

    p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> $stable(ctrl_byte));
endmodule

// File: tb/ata_tf_remap_tb_top.sv
module ata_tf_remap_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = '0;
    logic [10:0] host_addr = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [15:0] host_wdata = '0, host_rdata;
    logic        tf_rd, tf_wr;
    logic [3:0]  tf_idx;
    logic [15:0] tf_wdata, tf_rdata = '0;
    logic [7:0]  tf_status = '0;
    logic        drv_present = 1'b0;
    logic [3:0]  sel_nib = '0;
    logic        pd_set = 1'b0;
    logic [7:0]  ctrl_byte;
    logic        srst_req, pd_state, rdy_flag;

    int checks = 0, errors = 0;

    // model state
    logic [7:0] m_ctrl = '0, m_hold = '0;
    logic m_pd = 0, m_rdy = 0, m_srst = 0, m_cyc = 0;

    always #10 clk = ~clk;

    ata_tf_remap dut_i (
        .clk(clk), .rst(rst), .mode(mode), .host_addr(host_addr),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_idx(tf_idx),
        .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .tf_status(tf_status),
        .drv_present(drv_present), .sel_nib(sel_nib), .pd_set(pd_set),
        .ctrl_byte(ctrl_byte), .srst_req(srst_req), .pd_state(pd_state),
        .rdy_flag(rdy_flag)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // window decode per requirements R2..R6; returns {hit, idx}
    function automatic logic [4:0] bmap(input logic [1:0] m, input logic [10:0] a);
        case (m)
            2'd0: if (a < 11'h010) return {1'b1, a[3:0]};
                  else if (a >= 11'h400) return 5'b10000;
            2'd1: return {1'b1, a[3:0]};
            2'd2: if (a >= 11'h1F0 && a <= 11'h1FF) return {1'b1, 4'(a - 11'h1F0)};
                  else if (a >= 11'h3F0 && a <= 11'h3F7) return {1'b1, 4'(a - 11'h3E8)};
            default: if (a >= 11'h170 && a <= 11'h17F) return {1'b1, 4'(a - 11'h170)};
                  else if (a >= 11'h370 && a <= 11'h377) return {1'b1, 4'(a - 11'h368)};
        endcase
        return 5'b0;
    endfunction

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check_regs();
        chk("R10 ctrl_byte", {8'h0, ctrl_byte}, {8'h0, m_ctrl});
        chk("R10 srst_req", {15'h0, srst_req}, {15'h0, m_srst});
        chk("R11 pd_state", {15'h0, pd_state}, {15'h0, m_pd});
        chk("R11 rdy_flag", {15'h0, rdy_flag}, {15'h0, m_rdy});
    endtask

    task automatic access(input logic [1:0] m, input logic [10:0] a, input logic rd,
                          input logic wr, input logic [15:0] wd, input logic pds);
        logic [4:0] d;
        logic r, w, erd, ewr, wake, cwe, lane_ev, n_cyc;
        logic [3:0] eidx;
        logic [15:0] ewd, edata;
        logic [7:0] n_hold;
        string ftag;
        @(negedge clk);
        check_regs();
        mode = m; host_addr = a; host_rd = rd; host_wr = wr; host_wdata = wd; pd_set = pds;
        tf_rdata = 16'($urandom); tf_status = 8'($urandom);
        drv_present = 1'($urandom); sel_nib = 4'($urandom);
        #5;
        d = bmap(m, a);
        r = rd && !wr && d[4]; w = wr && d[4];
        erd = 0; ewr = 0; eidx = 0; ewd = wd; edata = 0; wake = 0; cwe = 0;
        lane_ev = 0; n_cyc = m_cyc; n_hold = m_hold; ftag = "R7";
        if (!d[4]) ftag = "R6";
        else case (d[3:0])
            4'h0, 4'h8: begin erd = r; ewr = w; if (r) edata = tf_rdata; end
            4'h9: begin
                lane_ev = r || w;
                if (r) begin
                    ftag = "R12";
                    if (!m_cyc) begin erd = 1; edata = {8'h0, tf_rdata[7:0]}; n_hold = tf_rdata[15:8]; end
                    else edata = {8'h0, m_hold};
                end
                if (w) begin
                    ftag = "R13";
                    if (!m_cyc) n_hold = wd[7:0];
                    else begin ewr = 1; ewd = {wd[7:0], m_hold}; end
                end
                if (lane_ev) n_cyc = !m_cyc;
            end
            4'hD: begin eidx = 1; erd = r; ewr = w; if (r) edata = tf_rdata; end
            4'hE: begin
                ftag = w ? "R10" : "R8";
                cwe = w;
                if (r && drv_present) edata = {8'h0, tf_status};
            end
            4'hF: begin
                ftag = w ? "R11" : "R9";
                eidx = 4'hF; ewr = w; wake = w;
                if (r) edata = {8'h0, 8'hC2 | {2'b00, ~sel_nib, 2'b00}};
            end
            default: begin eidx = d[3:0]; erd = r; ewr = w; wake = w; if (r) edata = tf_rdata; end
        endcase
        chk({ftag, " tf_rd"}, {15'h0, tf_rd}, {15'h0, erd});
        chk({ftag, " tf_wr"}, {15'h0, tf_wr}, {15'h0, ewr});
        chk({ftag, " host_rdata"}, host_rdata, edata);
        if (erd || ewr) chk({mode_tag(m), " tf_idx"}, {12'h0, tf_idx}, {12'h0, eidx});
        if (ewr) chk({ftag, " tf_wdata"}, tf_wdata, ewd);
        @(posedge clk);
        m_srst = cwe && wd[2];
        if (cwe) m_ctrl = wd[7:0];
        if (m_srst) begin m_pd = 0; m_rdy = 0; m_cyc = 0; m_hold = n_hold; end
        else begin
            m_cyc = n_cyc; m_hold = n_hold;
            if (pds) begin m_pd = 1; m_rdy = 0; end
            else if (wake && m_pd) begin m_pd = 0; m_rdy = 1; end
        end
        // stale hold kept on soft reset only matters in phase 1, which is cleared
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        #5;
        chk("R1 ctrl_byte", {8'h0, ctrl_byte}, 16'h0);
        chk("R1 pd_state", {15'h0, pd_state}, 16'h0);
        chk("R1 rdy_flag", {15'h0, rdy_flag}, 16'h0);
        chk("R1 srst_req", {15'h0, srst_req}, 16'h0);
        chk("R1 strobes", {14'h0, tf_rd, tf_wr}, 16'h0);
        chk("R1 host_rdata", host_rdata, 16'h0);
        // R2 memory alias edges
        access(2'd0, 11'h400, 1, 0, 16'h0, 0);
        access(2'd0, 11'h7FF, 0, 1, 16'hBEEF, 0);
        access(2'd0, 11'h010, 1, 0, 16'h0, 0);   // R6 miss
        access(2'd0, 11'h3FF, 0, 1, 16'h1111, 0); // R6 miss
        // R4 primary control block: 0x3F6 -> ctrl with soft reset
        access(2'd2, 11'h3F6, 0, 1, 16'h0006, 0);
        access(2'd2, 11'h3F6, 1, 0, 16'h0, 0);   // R8
        access(2'd2, 11'h3F8, 1, 0, 16'h0, 0);   // R6 out of window
        access(2'd2, 11'h3F7, 1, 0, 16'h0, 0);   // R9
        // R5 secondary windows
        access(2'd3, 11'h376, 1, 0, 16'h0, 0);
        access(2'd3, 11'h171, 0, 1, 16'h00A5, 0);
        access(2'd3, 11'h1F1, 1, 0, 16'h0, 0);   // R6 wrong window
        // R11 power-down and wake
        access(2'd1, 11'h000, 0, 0, 16'h0, 1);
        access(2'd1, 11'h008, 0, 1, 16'h1234, 0); // data write: no wake
        access(2'd1, 11'h00D, 0, 1, 16'h0055, 0); // features: no wake
        access(2'd1, 11'h007, 0, 1, 16'h0020, 0); // wakes
        access(2'd1, 11'h000, 0, 0, 16'h0, 1);
        access(2'd1, 11'h00F, 0, 1, 16'h0010, 1); // pd_set wins over wake
        access(2'd1, 11'h00E, 0, 1, 16'h0004, 1); // soft reset wins over pd_set
        // R12 / R13 odd-byte lane
        access(2'd1, 11'h009, 1, 0, 16'h0, 0);
        access(2'd1, 11'h009, 1, 0, 16'h0, 0);
        access(2'd1, 11'h009, 0, 1, 16'h00C3, 0);
        access(2'd1, 11'h009, 0, 1, 16'h003C, 0);
        access(2'd1, 11'h009, 0, 1, 16'h0077, 0);
        access(2'd1, 11'h00E, 0, 1, 16'h0004, 0); // R10 clears phase
        access(2'd1, 11'h009, 1, 1, 16'h0099, 0); // R7 both strobes = write
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [1:0]  m;
            logic [10:0] a;
            logic [3:0]  pick;
            logic [15:0] wd;
            m = 2'($urandom);
            pick = 4'($urandom);
            case (pick[1:0])
                2'd0: a = 11'h1F0 | 11'($urandom % 16);
                2'd1: a = 11'h3F0 | 11'($urandom % 16);
                2'd2: a = (m == 2'd3) ? (11'h170 | 11'($urandom % 16)) : (11'h370 | 11'($urandom % 16));
                default: a = 11'($urandom);
            endcase
            if (pick[3:2] == 2'd0 && m == 2'd0) a = 11'($urandom % 16);
            wd = 16'($urandom);
            if (($urandom % 4) != 0) wd[2] = 1'b0;
            access(m, a, 1'($urandom), 1'($urandom), wd, ($urandom % 16) == 0);
        end
        access(2'd1, 11'h000, 0, 0, 16'h0, 0);
        @(negedge clk);
        check_regs();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule